// File: doc/BRIEF.md
# Binary32 Floating-Point Multiplier

This block multiplies two single-precision binary32 operands and rounds the result in one of four directions, chosen per operation. A one-cycle `i_start` pulse captures both operands and the rounding code. Exactly four clock edges later, counting the edge that sampled the start, `o_done` pulses for one cycle. At that point `o_result` holds the product, together with four indication flags. The pipeline accepts a new operation on every cycle, so results leave in issue order at a rate of one per cycle.

The work is done in four registered steps:

- **Operand decode.** The operands are classified as zero, infinity, NaN or ordinary. The biased exponent sum is formed. Certain overflow and certain underflow are flagged at this step, before any significand bits exist.
- **Partial products.** The two 24-bit significands, each with its hidden one, are multiplied as two half-width partial products.
- **Product sum.** The two partial products are added into the 48-bit product.
- **Normalize and round.** The product is normalized. The rounding increments for all four modes are formed side by side, the requested one is applied, and the result is packed.

Subnormal operands are treated as zeros, and results too small to be normal are flushed to zero. Operands and results use the standard layout: sign in bit 31, biased exponent in bits 30:23 (bias 127), fraction in bits 22:0.

Top module: `fpm_mul_top`

## Requirements
- R1: For two ordinary operands, the sign of `o_result` is the XOR of the operand signs. The magnitude is the exact product of the two significands (each with its hidden one), scaled by the sum of the biased exponents minus 127 and rounded to 24 significant bits.
- R2: `o_done` is high for one cycle, exactly four rising edges after the edge that sampled `i_start`, and never at any other time. Starts on consecutive cycles give results on consecutive cycles, in issue order.
- R3: The `i_rmode` codes are:
  - 0: nearest, with ties going to an even last bit.
  - 1: toward zero.
  - 2: toward plus infinity.
  - 3: toward minus infinity.
- R4: `o_inexact` (flag bit 0) is set for an ordinary result exactly when any product bit below the kept 24 is nonzero.
- R5: A rounded biased exponent of 255 or more gives one of two results:
  - Infinity, with `o_inf` set, when the mode rounds away from zero for that sign (mode 0 always, mode 2 for a positive result, mode 3 for a negative result).
  - Otherwise the largest finite magnitude 0x7F7FFFFF with the product sign and `o_inf` clear.
  
  `o_inexact` is set in both cases.
- R6: A rounded biased exponent of 0 or less gives a zero with the product sign and `o_inexact` set. A rounded biased exponent of 1 is still delivered as a normal number.
- R7: An operand whose exponent field is 0 counts as zero, whatever its fraction. Zero times a finite value gives a zero carrying the XOR sign, with all flags clear.
- R8: Infinity times a nonzero non-NaN value gives an infinity carrying the XOR sign, with `o_inf` set and `o_inexact` clear.
- R9: Infinity times zero, with no NaN operand, gives 0x7FC00000 with `o_qnan` set and `o_snan` clear.
- R10: If either operand is a NaN, the result is that operand (operand A takes precedence) with fraction bit 22 forced to 1, and `o_qnan` is set. `o_snan` is set when any NaN operand has fraction bit 22 clear.
- R11: While `rst` is high, `o_done`, `o_result` and all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| i_start | input | 1 | Captures operands and rounding code this cycle |
| i_a | input | 32 | Operand A, binary32 |
| i_b | input | 32 | Operand B, binary32 |
| i_rmode | input | 2 | Rounding direction code (R3) |
| o_done | output | 1 | One-cycle result strobe |
| o_result | output | 32 | Product, binary32 |
| o_snan | output | 1 | A signaling NaN operand was seen |
| o_qnan | output | 1 | Result is a quiet NaN |
| o_inf | output | 1 | Result is an infinity |
| o_inexact | output | 1 | Result differs from the exact product |

## Verification
The properties relate each strobe to the operands present on the start cycle four edges earlier. They therefore assume that operands and rounding code matter only on the start cycle, and that reset stays low for the whole flight of an operation. The stimulus changes `i_a`, `i_b` and `i_rmode` only together with a start pulse and asserts reset only before the first operation. Every 2-bit rounding code is valid, so random traffic draws all four codes freely. Random exponents are mostly drawn from a middle band so that ordinary results dominate, with occasional full-range exponents to reach the flush, overflow, infinity and NaN paths alongside the directed boundary vectors.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  localparam int EXP_W   = 8;
  localparam int FRAC_W  = 23;
  localparam int WORD_W  = 1 + EXP_W + FRAC_W;
  localparam int SIG_W   = FRAC_W + 1;
  localparam int PROD_W  = 2 * SIG_W;
  localparam int ESUM_W  = EXP_W + 2;
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int EMAX    = (1 << EXP_W) - 1;
  localparam int RM_CNT  = 4;
  localparam int LATENCY = 4;

  typedef enum logic [1:0] {
    RM_NEAR_EVEN = 2'd0,
    RM_TO_ZERO   = 2'd1,
    RM_UP        = 2'd2,
    RM_DOWN      = 2'd3
  } rmode_e;

  typedef enum logic [1:0] {
    SP_NONE = 2'd0,
    SP_ZERO = 2'd1,
    SP_INF  = 2'd2,
    SP_NAN  = 2'd3
  } special_e;

  typedef struct packed {
    logic                     sign;
    logic signed [ESUM_W-1:0] esum;
    rmode_e                   rmode;
    special_e                 kind;
    logic [WORD_W-1:0]        nan_word;
    logic                     snan;
    logic                     early_ovf;
    logic                     early_unf;
  } ctl_t;

  typedef struct packed {
    logic snan;
    logic qnan;
    logic inf;
    logic inexact;
  } flags_t;

  // increment decision for one rounding direction
  function automatic logic round_inc(input rmode_e m, input logic sign,
                                     input logic lsb, input logic guard,
                                     input logic sticky);
    logic r;
    unique case (m)
      RM_NEAR_EVEN: r = guard & (sticky | lsb);
      RM_TO_ZERO:   r = 1'b0;
      RM_UP:        r = ~sign & (guard | sticky);
      default:      r = sign & (guard | sticky);
    endcase
    return r;
  endfunction

  // whether an out-of-range magnitude becomes infinity
  function automatic logic ovf_to_inf(input rmode_e m, input logic sign);
    logic r;
    unique case (m)
      RM_NEAR_EVEN: r = 1'b1;
      RM_TO_ZERO:   r = 1'b0;
      RM_UP:        r = ~sign;
      default:      r = sign;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/fpm_prenorm.sv
module fpm_prenorm
  import fpm_pkg::*;
(
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  input  rmode_e            rmode_i,
  output ctl_t              ctl_o,
  output logic [SIG_W-1:0]  siga_o,
  output logic [SIG_W-1:0]  sigb_o
);
  localparam logic [WORD_W-1:0] QNAN_DEF  = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic [WORD_W-1:0] QUIET_BIT = WORD_W'(1) << (FRAC_W - 1);

  logic [WORD_W-1:0] op [2];
  logic [EXP_W-1:0]  ex [2];
  logic [FRAC_W-1:0] fr [2];
  logic [1:0] is_zero, is_inf, is_nan, is_snan;
  logic signed [ESUM_W-1:0] esum;

  assign op[0] = a_i;
  assign op[1] = b_i;

  for (genvar k = 0; k < 2; k++) begin : g_dec
    assign ex[k]      = op[k][WORD_W-2 -: EXP_W];
    assign fr[k]      = op[k][FRAC_W-1:0];
    assign is_zero[k] = (ex[k] == '0);
    assign is_inf[k]  = (&ex[k]) && (fr[k] == '0);
    assign is_nan[k]  = (&ex[k]) && (fr[k] != '0);
    assign is_snan[k] = is_nan[k] && !fr[k][FRAC_W-1];
  end

  assign esum = $signed({2'b00, ex[0]}) + $signed({2'b00, ex[1]}) - $signed(ESUM_W'(BIAS));

  always_comb begin
    ctl_o.sign      = op[0][WORD_W-1] ^ op[1][WORD_W-1];
    ctl_o.esum      = esum;
    ctl_o.rmode     = rmode_i;
    ctl_o.snan      = |is_snan;
    ctl_o.early_ovf = (esum >= $signed(ESUM_W'(EMAX)));
    ctl_o.early_unf = (esum < $signed(ESUM_W'(0)));
    if (is_nan[0])      ctl_o.nan_word = op[0] | QUIET_BIT;
    else if (is_nan[1]) ctl_o.nan_word = op[1] | QUIET_BIT;
    else                ctl_o.nan_word = QNAN_DEF;
    if (|is_nan)
      ctl_o.kind = SP_NAN;
    else if ((is_inf[0] && is_zero[1]) || (is_inf[1] && is_zero[0]))
      ctl_o.kind = SP_NAN;
    else if (|is_inf)
      ctl_o.kind = SP_INF;
    else if (|is_zero)
      ctl_o.kind = SP_ZERO;
    else
      ctl_o.kind = SP_NONE;
  end

  assign siga_o = {1'b1, fr[0]};
  assign sigb_o = {1'b1, fr[1]};
endmodule

// File: rtl/fpm_sig_mul.sv
module fpm_sig_mul #(
  parameter int A_W   = 24,
  parameter int B_W   = 24,
  parameter int SPLIT = 12
) (
  input  logic               clk,
  input  logic [A_W-1:0]     a_i,
  input  logic [B_W-1:0]     b_i,
  output logic [A_W+B_W-1:0] prod_o
);
  localparam int P_W  = A_W + B_W;
  localparam int LO_W = A_W + SPLIT;
  localparam int HI_W = A_W + B_W - SPLIT;

  logic [LO_W-1:0] pp_lo;
  logic [HI_W-1:0] pp_hi;

  // cycle one: two narrow partial products
  always_ff @(posedge clk) begin
    pp_lo <= LO_W'(a_i) * LO_W'(b_i[SPLIT-1:0]);
    pp_hi <= HI_W'(a_i) * HI_W'(b_i[B_W-1:SPLIT]);
  end

  // cycle two: aligned sum
  always_ff @(posedge clk) begin
    prod_o <= P_W'(pp_lo) + (P_W'(pp_hi) << SPLIT);
  end
endmodule

// File: rtl/fpm_round.sv
module fpm_round
  import fpm_pkg::*;
(
  input  logic [PROD_W-1:0] prod_i,
  input  ctl_t              ctl_i,
  output logic [WORD_W-1:0] result_o,
  output flags_t            flags_o
);
  logic                     hi, guard, sticky, inc;
  logic [SIG_W-1:0]         mant;
  logic [SIG_W:0]           mant_r;
  logic [RM_CNT-1:0]        inc_by_mode;
  logic [FRAC_W-1:0]        frac;
  logic signed [ESUM_W-1:0] efin;
  logic                     ovf, unf, away;

  assign hi     = prod_i[PROD_W-1];
  assign mant   = hi ? prod_i[PROD_W-1 -: SIG_W] : prod_i[PROD_W-2 -: SIG_W];
  assign guard  = hi ? prod_i[PROD_W-1-SIG_W] : prod_i[PROD_W-2-SIG_W];
  assign sticky = hi ? |prod_i[PROD_W-2-SIG_W:0] : |prod_i[PROD_W-3-SIG_W:0];

  // every direction evaluated side by side, then one picked
  for (genvar m = 0; m < RM_CNT; m++) begin : g_rnd
    assign inc_by_mode[m] = round_inc(rmode_e'(m), ctl_i.sign, mant[0], guard, sticky);
  end
  assign inc = inc_by_mode[ctl_i.rmode];

  assign mant_r = {1'b0, mant} + (SIG_W+1)'(inc);
  assign frac   = mant_r[SIG_W] ? mant_r[FRAC_W:1] : mant_r[FRAC_W-1:0];
  assign efin   = ctl_i.esum + $signed(ESUM_W'(hi)) + $signed(ESUM_W'(mant_r[SIG_W]));
  assign ovf    = ctl_i.early_ovf | (efin >= $signed(ESUM_W'(EMAX)));
  assign unf    = ctl_i.early_unf | (efin <= $signed(ESUM_W'(0)));
  assign away   = ovf_to_inf(ctl_i.rmode, ctl_i.sign);

  always_comb begin
    flags_o  = '0;
    result_o = '0;
    unique case (ctl_i.kind)
      SP_NAN: begin
        result_o     = ctl_i.nan_word;
        flags_o.qnan = 1'b1;
        flags_o.snan = ctl_i.snan;
      end
      SP_INF: begin
        result_o    = {ctl_i.sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        flags_o.inf = 1'b1;
      end
      SP_ZERO: result_o = {ctl_i.sign, {(WORD_W-1){1'b0}}};
      default: begin
        if (ovf) begin
          flags_o.inexact = 1'b1;
          if (away) begin
            result_o    = {ctl_i.sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            flags_o.inf = 1'b1;
          end else begin
            result_o = {ctl_i.sign, {(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
          end
        end else if (unf) begin
          result_o        = {ctl_i.sign, {(WORD_W-1){1'b0}}};
          flags_o.inexact = 1'b1;
        end else begin
          result_o        = {ctl_i.sign, efin[EXP_W-1:0], frac};
          flags_o.inexact = guard | sticky;
        end
      end
    endcase
  end
endmodule

// File: rtl/fpm_mul_top.sv
module fpm_mul_top
  import fpm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              i_start,
  input  logic [WORD_W-1:0] i_a,
  input  logic [WORD_W-1:0] i_b,
  input  logic [1:0]        i_rmode,
  output logic              o_done,
  output logic [WORD_W-1:0] o_result,
  output logic              o_snan,
  output logic              o_qnan,
  output logic              o_inf,
  output logic              o_inexact
);
  ctl_t              ctl_d, ctl_s1, ctl_s2, ctl_s3;
  logic [SIG_W-1:0]  siga_d, sigb_d, siga_s1, sigb_s1;
  logic [PROD_W-1:0] prod_s3;
  logic              v1, v2, v3;
  logic [WORD_W-1:0] rnd_word;
  flags_t            rnd_flags;

  fpm_prenorm u_pre (
    .a_i     (i_a),
    .b_i     (i_b),
    .rmode_i (rmode_e'(i_rmode)),
    .ctl_o   (ctl_d),
    .siga_o  (siga_d),
    .sigb_o  (sigb_d)
  );

  // decode stage registers
  always_ff @(posedge clk) begin
    ctl_s1  <= ctl_d;
    siga_s1 <= siga_d;
    sigb_s1 <= sigb_d;
    ctl_s2  <= ctl_s1;
    ctl_s3  <= ctl_s2;
  end

  fpm_sig_mul #(
    .A_W   (SIG_W),
    .B_W   (SIG_W),
    .SPLIT (SIG_W / 2)
  ) u_mul (
    .clk    (clk),
    .a_i    (siga_s1),
    .b_i    (sigb_s1),
    .prod_o (prod_s3)
  );

  fpm_round u_rnd (
    .prod_i   (prod_s3),
    .ctl_i    (ctl_s3),
    .result_o (rnd_word),
    .flags_o  (rnd_flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      v3 <= 1'b0;
    end else begin
      v1 <= i_start;
      v2 <= v1;
      v3 <= v2;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      o_done    <= 1'b0;
      o_result  <= '0;
      o_snan    <= 1'b0;
      o_qnan    <= 1'b0;
      o_inf     <= 1'b0;
      o_inexact <= 1'b0;
    end else begin
      o_done <= v3;
      if (v3) begin
        o_result  <= rnd_word;
        o_snan    <= rnd_flags.snan;
        o_qnan    <= rnd_flags.qnan;
        o_inf     <= rnd_flags.inf;
        o_inexact <= rnd_flags.inexact;
      end
    end
  end
endmodule

// File: rtl/fpm_mul_chk.sv
module fpm_mul_chk
  import fpm_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              i_start,
  input logic [WORD_W-1:0] i_a,
  input logic [WORD_W-1:0] i_b,
  input logic              o_done,
  input logic [WORD_W-1:0] o_result,
  input logic              o_snan,
  input logic              o_qnan,
  input logic              o_inf,
  input logic              o_inexact
);
  logic a_nan, b_nan, a_inf, b_inf, a_zero, b_zero, inf_zero, inf_exact, sgn;

  assign a_nan     = (&i_a[30:23]) && (i_a[22:0] != '0);
  assign b_nan     = (&i_b[30:23]) && (i_b[22:0] != '0);
  assign a_inf     = (&i_a[30:23]) && (i_a[22:0] == '0);
  assign b_inf     = (&i_b[30:23]) && (i_b[22:0] == '0);
  assign a_zero    = (i_a[30:23] == '0);
  assign b_zero    = (i_b[30:23] == '0);
  assign inf_zero  = !(a_nan || b_nan) && ((a_inf && b_zero) || (b_inf && a_zero));
  assign inf_exact = !(a_nan || b_nan) && (a_inf || b_inf) && !(a_zero || b_zero);
  assign sgn       = i_a[31] ^ i_b[31];

  a_r2_latency_fwd: assert property (@(posedge clk) disable iff (rst)
    i_start |-> ##LATENCY o_done);

  a_r2_latency_back: assert property (@(posedge clk) disable iff (rst)
    o_done |-> $past(i_start, LATENCY));

  a_r1_sign_xor: assert property (@(posedge clk) disable iff (rst)
    (o_done && !o_qnan) |-> (o_result[31] == $past(sgn, LATENCY)));

  a_r9_inf_times_zero: assert property (@(posedge clk) disable iff (rst)
    (o_done && $past(inf_zero, LATENCY)) |-> (o_result == 32'h7FC00000 && o_qnan && !o_snan));

  a_r10_snan_quieted: assert property (@(posedge clk) disable iff (rst)
    (o_done && o_snan) |-> (o_qnan && o_result[22]));

  a_r6_no_subnormal_out: assert property (@(posedge clk) disable iff (rst)
    (o_done && o_result[30:23] == '0) |-> (o_result[22:0] == '0));

  a_r8_exact_inf: assert property (@(posedge clk) disable iff (rst)
    (o_done && $past(inf_exact, LATENCY)) |-> (o_inf && !o_inexact));
endmodule

bind fpm_mul_top fpm_mul_chk u_fpm_mul_chk (
  .clk       (clk),
  .rst       (rst),
  .i_start   (i_start),
  .i_a       (i_a),
  .i_b       (i_b),
  .o_done    (o_done),
  .o_result  (o_result),
  .o_snan    (o_snan),
  .o_qnan    (o_qnan),
  .o_inf     (o_inf),
  .o_inexact (o_inexact)
);

// File: tb/test_fpm_mul_top.sv
module test_fpm_mul_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        i_start = 1'b0;
  logic [31:0] i_a = '0;
  logic [31:0] i_b = '0;
  logic [1:0]  i_rmode = '0;
  logic        o_done, o_snan, o_qnan, o_inf, o_inexact;
  logic [31:0] o_result;

  always #4 clk = ~clk;

  fpm_mul_top i_fpm_mul_top (
    .clk       (clk),
    .rst       (rst),
    .i_start   (i_start),
    .i_a       (i_a),
    .i_b       (i_b),
    .i_rmode   (i_rmode),
    .o_done    (o_done),
    .o_result  (o_result),
    .o_snan    (o_snan),
    .o_qnan    (o_qnan),
    .o_inf     (o_inf),
    .o_inexact (o_inexact)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_fail = 0;
  bit over = 1'b0;

  logic [35:0] exp_q[$];
  int          cyc_q[$];
  string       tag_q[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  // expected value: {result, snan, qnan, inf, inexact}
  function automatic logic [35:0] ref_mul(input logic [31:0] a, input logic [31:0] b,
                                          input logic [1:0] rm);
    int ea, eb, e, sh;
    logic s, an, bn, ai, bi, az, bz, up, inx;
    logic [63:0] p, mant, rem, half;
    ea = int'(a[30:23]);
    eb = int'(b[30:23]);
    s  = a[31] ^ b[31];
    an = (ea == 255) && (a[22:0] != 0);
    bn = (eb == 255) && (b[22:0] != 0);
    ai = (ea == 255) && (a[22:0] == 0);
    bi = (eb == 255) && (b[22:0] == 0);
    az = (ea == 0);
    bz = (eb == 0);
    if (an || bn)
      return {(an ? (a | 32'h00400000) : (b | 32'h00400000)),
              (an && !a[22]) || (bn && !b[22]), 3'b100};
    if ((ai && bz) || (bi && az)) return {32'h7FC00000, 4'b0100};
    if (ai || bi) return {s, 8'hFF, 23'h0, 4'b0010};
    if (az || bz) return {s, 31'h0, 4'b0000};
    p    = {40'h0, 1'b1, a[22:0]} * {40'h0, 1'b1, b[22:0]};
    sh   = p[47] ? 24 : 23;
    e    = ea + eb - 127 + (p[47] ? 1 : 0);
    mant = p >> sh;
    rem  = p & ((64'd1 << sh) - 64'd1);
    half = 64'd1 << (sh - 1);
    case (rm)
      2'd0:    up = (rem > half) || (rem == half && mant[0]);
      2'd1:    up = 1'b0;
      2'd2:    up = !s && (rem != 0);
      default: up = s && (rem != 0);
    endcase
    mant = mant + 64'(up);
    if (mant == (64'd1 << 24)) begin
      mant = mant >> 1;
      e++;
    end
    inx = (rem != 0);
    if (e >= 255) begin
      if (rm == 2'd0 || (rm == 2'd2 && !s) || (rm == 2'd3 && s))
        return {s, 8'hFF, 23'h0, 4'b0011};
      return {s, 8'hFE, 23'h7FFFFF, 4'b0001};
    end
    if (e <= 0) return {s, 31'h0, 4'b0001};
    return {s, 8'(e), mant[22:0], 3'b000, inx};
  endfunction

  task automatic issue(input logic [31:0] a, input logic [31:0] b, input logic [1:0] rm,
                       input logic [35:0] expv, input string tag);
    @(negedge clk);
    i_start = 1'b1;
    i_a     = a;
    i_b     = b;
    i_rmode = rm;
    exp_q.push_back(expv);
    cyc_q.push_back(cyc);
    tag_q.push_back(tag);
  endtask

  task automatic issue_ref(input logic [31:0] a, input logic [31:0] b, input logic [1:0] rm,
                           input string tag);
    issue(a, b, rm, ref_mul(a, b, rm), tag);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      i_start = 1'b0;
    end
  endtask

  // monitor: pop and compare as results appear
  always @(negedge clk) begin
    if (!rst && o_done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2", "done without pending item", 64'(o_done), 64'd0);
      end else begin
        logic [35:0] e;
        int          c;
        string       t;
        e = exp_q.pop_front();
        c = cyc_q.pop_front();
        t = tag_q.pop_front();
        check((cyc - c) == 4, "R2", "latency", 64'(cyc - c), 64'd4);
        check({o_result, o_snan, o_qnan, o_inf, o_inexact} == e, t, "result/flags",
              64'({o_result, o_snan, o_qnan, o_inf, o_inexact}), 64'(e));
      end
    end
  end

  task automatic finish_run;
    if (!over) begin
      over = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "R2", "watchdog expired", 64'(exp_q.size()), 64'd0);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R11: reset state
    check({o_done, o_result, o_snan, o_qnan, o_inf, o_inexact} == '0, "R11", "reset outputs",
          64'({o_done, o_result, o_snan, o_qnan, o_inf, o_inexact}), 64'd0);
    rst = 1'b0;
    idle(2);

    // R1: plain products and sign
    issue(32'h3FC00000, 32'h40000000, 2'd0, {32'h40400000, 4'b0000}, "R1");
    issue(32'hBFC00000, 32'h40000000, 2'd0, {32'hC0400000, 4'b0000}, "R1");
    idle(6);
    // R3 R4: sticky-only discard under every mode, issued back to back (R2)
    issue(32'h3F800001, 32'h3F800001, 2'd0, {32'h3F800002, 4'b0001}, "R4");
    issue(32'h3F800001, 32'h3F800001, 2'd1, {32'h3F800002, 4'b0001}, "R3");
    issue(32'h3F800001, 32'h3F800001, 2'd2, {32'h3F800003, 4'b0001}, "R3");
    issue(32'h3F800001, 32'h3F800001, 2'd3, {32'h3F800002, 4'b0001}, "R3");
    issue(32'hBF800001, 32'h3F800001, 2'd3, {32'hBF800003, 4'b0001}, "R3");
    issue(32'hBF800001, 32'h3F800001, 2'd2, {32'hBF800002, 4'b0001}, "R3");
    // R3: exact ties, odd and even last bit
    issue(32'h3FC00000, 32'h3F800001, 2'd0, {32'h3FC00002, 4'b0001}, "R3");
    issue(32'h3FC00000, 32'h3F800001, 2'd1, {32'h3FC00001, 4'b0001}, "R3");
    issue(32'h3FC00000, 32'h3F800003, 2'd0, {32'h3FC00004, 4'b0001}, "R3");
    issue(32'h3FC00000, 32'h3F800003, 2'd2, {32'h3FC00005, 4'b0001}, "R3");
    idle(6);
    // R5: overflow by direction
    issue(32'h7F000000, 32'h40000000, 2'd0, {32'h7F800000, 4'b0011}, "R5");
    issue(32'h7F000000, 32'h40000000, 2'd1, {32'h7F7FFFFF, 4'b0001}, "R5");
    issue(32'hFF000000, 32'h40000000, 2'd2, {32'hFF7FFFFF, 4'b0001}, "R5");
    issue(32'hFF000000, 32'h40000000, 2'd3, {32'hFF800000, 4'b0011}, "R5");
    issue(32'h7F7FFFFF, 32'h7F7FFFFF, 2'd0, {32'h7F800000, 4'b0011}, "R5");
    // R6: underflow and the smallest normal result
    issue(32'h00800000, 32'h3F000000, 2'd0, {32'h00000000, 4'b0001}, "R6");
    issue(32'h80800000, 32'h3F000000, 2'd2, {32'h80000000, 4'b0001}, "R6");
    issue(32'h00C00000, 32'h3F2AAAAB, 2'd0, {32'h00800000, 4'b0001}, "R6");
    // R7: zeros and flushed subnormals
    issue(32'h00000001, 32'h3F800000, 2'd0, {32'h00000000, 4'b0000}, "R7");
    issue(32'h80000001, 32'h3F800000, 2'd2, {32'h80000000, 4'b0000}, "R7");
    issue(32'h00000000, 32'hC0000000, 2'd0, {32'h80000000, 4'b0000}, "R7");
    // R8: infinities
    issue(32'h7F800000, 32'hC0000000, 2'd0, {32'hFF800000, 4'b0010}, "R8");
    issue(32'hFF800000, 32'hFF800000, 2'd1, {32'h7F800000, 4'b0010}, "R8");
    // R9: infinity times zero
    issue(32'h7F800000, 32'h00000000, 2'd0, {32'h7FC00000, 4'b0100}, "R9");
    issue(32'hFF800000, 32'h00000005, 2'd3, {32'h7FC00000, 4'b0100}, "R9");
    // R10: NaN propagation
    issue(32'h7F800001, 32'h3F800000, 2'd0, {32'h7FC00001, 4'b1100}, "R10");
    issue(32'h3F800000, 32'hFF800002, 2'd0, {32'hFFC00002, 4'b1100}, "R10");
    issue(32'hFFC00005, 32'h7F800000, 2'd0, {32'hFFC00005, 4'b0100}, "R10");
    issue(32'h7FC00000, 32'h7F800001, 2'd0, {32'h7FC00000, 4'b1100}, "R10");
    issue(32'h00000000, 32'h7FC00123, 2'd0, {32'h7FC00123, 4'b0100}, "R10");
    idle(8);

    // R1 R3 R4 random traffic with irregular gaps
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a, b;
      logic [7:0]  ea, eb;
      ea = ($urandom_range(0, 7) == 0) ? 8'($urandom_range(0, 255)) : 8'($urandom_range(70, 185));
      eb = ($urandom_range(0, 7) == 0) ? 8'($urandom_range(0, 255)) : 8'($urandom_range(70, 185));
      a  = {1'($urandom_range(0, 1)), ea, 23'($urandom())};
      b  = {1'($urandom_range(0, 1)), eb, 23'($urandom())};
      issue_ref(a, b, 2'($urandom_range(0, 3)), "R1 R3 R4 random");
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
    end
    idle(1);
    while (exp_q.size() != 0) @(negedge clk);
    idle(3);
    check(o_done == 1'b0, "R2", "no stray done", 64'(o_done), 64'd0);
    finish_run();
  end
endmodule